// File: doc/BRIEF.md
# Multi-Level Overload Current Limiter

This block chooses which current limit a power stage applies when the load briefly rises above its base limit. A comparator outside the block reports whether the measured current is above the base limit, and a millisecond tick paces all timing. When an excursion starts, the block raises the limit to a higher level for a fixed number of ticks and then returns to the base limit. In three-level mode the excursion steps down through an intermediate level before returning to base.

After an excursion, the limiter is not ready for a new one until a rearm rule is met. A policy input picks the rule. With the policy off, rearming waits for a tick at which the current is below the base limit. With the policy on, rearming waits for a fixed long interval, counted from the start of the excursion, to elapse, whatever the current does. The block only selects a level code and sequences it in time. Sensing and the limit arithmetic belong to the surrounding logic.

Top module: `ovld_limiter`

## Requirements
- R1: After reset `level_o` is 2'b00 (base), `active_o` is 0 and `rearm_o` is 1.
- R2: One cycle after `ovld_en_i` is sampled low, `level_o` is base, `active_o` is 0 and `rearm_o` is 1. An above-base tick sampled while `ovld_en_i` is low starts no excursion.
- R3: An excursion starts only on a clock edge where `tick_i`, `over_base_i` and `ovld_en_i` are all 1 while `rearm_o` is 1. The outputs change on the cycle after that edge. Without a tick, the block stays rearmed.
- R4: In two-level mode the raised level is 2'b01 (1.5x base) when `hi_sel_i` is 0 and 2'b10 (2x base) when it is 1.
- R5: Each step lasts one duration: DUR_SHORT ticks (default 25) when `dur_sel_i` is 0, DUR_LONG ticks (default 50) when it is 1. The step ends on the tick that completes the duration, counted after the starting tick.
- R6: In three-level mode an excursion shows 2'b10 for one duration, then 2'b01 for one duration, then base. `hi_sel_i` has no effect in this mode.
- R7: With `tmax_en_i` at 0, once the excursion has returned to base, the block rearms only on a tick that samples `over_base_i` at 0. Ticks above base keep `rearm_o` at 0.
- R8: With `tmax_en_i` at 1, the block rearms on the tick that completes TMAX_MULT durations (default 250 ticks for the short duration), counted from the starting tick, even if `over_base_i` stays 1.
- R9: `active_o` is 1 exactly when `level_o` is not base, and `rearm_o` is 0 for the whole excursion and hold period.
- R10: The duration select and the three-level enable are captured when the excursion starts. Changes to them during an excursion do not alter its levels or timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle millisecond tick |
| over_base_i | input | 1 | Current above base limit |
| ovld_en_i | input | 1 | Overload function enable |
| three_lvl_en_i | input | 1 | Three-level sequence enable |
| hi_sel_i | input | 1 | Raised level select: 0 = 1.5x, 1 = 2x |
| dur_sel_i | input | 1 | Step duration select: 0 = short, 1 = long |
| tmax_en_i | input | 1 | Rearm policy: 1 = fixed maximum interval |
| level_o | output | 2 | Active limit code: 00 base, 01 1.5x, 10 2x |
| active_o | output | 1 | Raised limit in force |
| rearm_o | output | 1 | Ready to accept a new excursion |

## Verification
The hardest state to reach is the interval-policy rearm. The current has to stay above base through the whole excursion and the hold phase, and then rearm must happen on the exact 250th tick and not one tick earlier. The stimulus keeps the comparator input high and fires a tick on every cycle, so the full interval passes in a few hundred cycles. It checks every tick on the way, which pins the edge to a single cycle. The configuration inputs are also changed in the middle of an excursion to show that the captured settings hold.

// File: rtl/ovld_pkg.sv
package ovld_pkg;
  typedef enum logic [1:0] {
    LVL_BASE = 2'b00,
    LVL_X1P5 = 2'b01,
    LVL_X2   = 2'b10
  } lvl_e;

  typedef enum logic [1:0] {
    ST_ARMED = 2'd0,
    ST_HIGH  = 2'd1,
    ST_MID   = 2'd2,
    ST_HOLD  = 2'd3
  } st_e;
endpackage

// File: rtl/ovld_tick_counter.sv
module ovld_tick_counter #(
  parameter int W = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         tick_i,
  input  logic [W-1:0] limit_i,
  output logic         hit_o
);
  logic [W-1:0] cnt_q;
  logic [W:0]   nxt;

  assign nxt   = {1'b0, cnt_q} + 1'b1;
  assign hit_o = tick_i && (nxt >= {1'b0, limit_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (tick_i)  cnt_q <= hit_o ? limit_i : nxt[W-1:0];
  end

  // R5
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= limit_i);
endmodule

// File: rtl/ovld_seq_fsm.sv
module ovld_seq_fsm
  import ovld_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       over_i,
  input  logic       en_i,
  input  logic       three_i,
  input  logic       hi_sel_i,
  input  logic       tmax_en_i,
  input  logic       step_hit_i,
  input  logic       span_hit_i,
  output logic       start_o,
  output logic [1:0] level_o,
  output logic       active_o,
  output logic       rearm_o
);
  st_e  st_q, st_d;
  lvl_e lvl_q, lvl_d;
  logic three_q, three_d;

  assign start_o = (st_q == ST_ARMED) && tick_i && over_i && en_i;

  always_comb begin
    st_d    = st_q;
    lvl_d   = lvl_q;
    three_d = three_q;
    if (!en_i) begin
      st_d  = ST_ARMED;
      lvl_d = LVL_BASE;
    end else begin
      unique case (st_q)
        ST_ARMED: if (start_o) begin
          st_d    = ST_HIGH;
          three_d = three_i;
          lvl_d   = (three_i || hi_sel_i) ? LVL_X2 : LVL_X1P5;
        end
        ST_HIGH: if (step_hit_i) begin
          st_d  = three_q ? ST_MID : ST_HOLD;
          lvl_d = three_q ? LVL_X1P5 : LVL_BASE;
        end
        ST_MID: if (step_hit_i) begin
          st_d  = ST_HOLD;
          lvl_d = LVL_BASE;
        end
        ST_HOLD: if (tmax_en_i ? span_hit_i : (tick_i && !over_i)) begin
          st_d = ST_ARMED;
        end
        default: begin
          st_d  = ST_ARMED;
          lvl_d = LVL_BASE;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_ARMED;
      lvl_q   <= LVL_BASE;
      three_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      lvl_q   <= lvl_d;
      three_q <= three_d;
    end
  end

  assign level_o  = lvl_q;
  assign active_o = (st_q == ST_HIGH) || (st_q == ST_MID);
  assign rearm_o  = (st_q == ST_ARMED);

  // R2
  dis_base_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (lvl_q == LVL_BASE && st_q == ST_ARMED));
  // R3
  no_tick_armed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_ARMED && !tick_i) |=> st_q == ST_ARMED);
  // R4
  raise_x1p5_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_ARMED && en_i && tick_i && over_i && !three_i && !hi_sel_i)
      |=> lvl_q == LVL_X1P5);
  // R6
  raise_three_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_ARMED && en_i && tick_i && over_i && three_i)
      |=> lvl_q == LVL_X2);
  // R7
  hold_over_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_HOLD && en_i && !tmax_en_i && over_i) |=> st_q == ST_HOLD);
  // R9
  act_lvl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_o == (lvl_q != LVL_BASE));
endmodule

// File: rtl/ovld_limiter.sv
module ovld_limiter
  import ovld_pkg::*;
#(
  parameter int DUR_SHORT = 25,
  parameter int DUR_LONG  = 50,
  parameter int TMAX_MULT = 10
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       over_base_i,
  input  logic       ovld_en_i,
  input  logic       three_lvl_en_i,
  input  logic       hi_sel_i,
  input  logic       dur_sel_i,
  input  logic       tmax_en_i,
  output logic [1:0] level_o,
  output logic       active_o,
  output logic       rearm_o
);
  localparam int STEP_W     = $clog2(DUR_LONG + 1);
  localparam int SPAN_SHORT = DUR_SHORT * TMAX_MULT;
  localparam int SPAN_LONG  = DUR_LONG * TMAX_MULT;
  localparam int SPAN_W     = $clog2(SPAN_LONG + 1);

  logic              dur_q;
  logic              start, step_hit, span_hit, step_clr;
  logic [STEP_W-1:0] step_lim;
  logic [SPAN_W-1:0] span_lim;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    dur_q <= 1'b0;
    else if (start) dur_q <= dur_sel_i;
  end

  assign step_lim = dur_q ? STEP_W'(DUR_LONG)  : STEP_W'(DUR_SHORT);
  assign span_lim = dur_q ? SPAN_W'(SPAN_LONG) : SPAN_W'(SPAN_SHORT);
  assign step_clr = rearm_o || step_hit;

  ovld_tick_counter #(.W(STEP_W)) i_step_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (step_clr),
    .tick_i  (tick_i),
    .limit_i (step_lim),
    .hit_o   (step_hit)
  );

  ovld_tick_counter #(.W(SPAN_W)) i_span_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (rearm_o),
    .tick_i  (tick_i),
    .limit_i (span_lim),
    .hit_o   (span_hit)
  );

  ovld_seq_fsm i_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .over_i     (over_base_i),
    .en_i       (ovld_en_i),
    .three_i    (three_lvl_en_i),
    .hi_sel_i   (hi_sel_i),
    .tmax_en_i  (tmax_en_i),
    .step_hit_i (step_hit),
    .span_hit_i (span_hit),
    .start_o    (start),
    .level_o    (level_o),
    .active_o   (active_o),
    .rearm_o    (rearm_o)
  );

  // R9
  rearm_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rearm_o |-> !active_o);
endmodule

// File: tb/test_ovld_limiter.sv
module test_ovld_limiter;
  localparam logic [1:0] B  = 2'b00;
  localparam logic [1:0] X1 = 2'b01;
  localparam logic [1:0] X2 = 2'b10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, over = 1'b0, en = 1'b0, three = 1'b0;
  logic hi = 1'b0, dsel = 1'b0, tmax = 1'b0;
  logic [1:0] level;
  logic active, rearm;

  always #2 clk = ~clk;

  ovld_limiter i_ovld_limiter (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .over_base_i(over),
    .ovld_en_i(en), .three_lvl_en_i(three), .hi_sel_i(hi),
    .dur_sel_i(dsel), .tmax_en_i(tmax),
    .level_o(level), .active_o(active), .rearm_o(rearm)
  );

  typedef struct {
    logic [1:0] lvl;
    logic       act;
    logic       rdy;
    string      tag;
  } exp_t;

  exp_t sb_q[$];
  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  // driver: called at a negedge, drives one cycle and queues its expected result
  task automatic cyc(input logic t, input logic ov, input logic [1:0] l,
                     input logic a, input logic r, input string tag);
    exp_t e;
    tick = t;
    over = ov;
    e.lvl = l; e.act = a; e.rdy = r; e.tag = tag;
    sb_q.push_back(e);
    @(negedge clk);
  endtask

  task automatic run(input int n, input logic t, input logic ov, input logic [1:0] l,
                     input logic a, input logic r, input string tag);
    for (int k = 0; k < n; k++) cyc(t, ov, l, a, r, tag);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        n_chk++;
        if (level !== e.lvl || active !== e.act || rearm !== e.rdy) begin
          n_fail++;
          $display("FAIL %s: level=%0d active=%0b rearm=%0b expected level=%0d active=%0b rearm=%0b",
                   e.tag, level, active, rearm, e.lvl, e.act, e.rdy);
        end
      end
    end
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cyc(0, 0, B, 0, 1, "R1 reset state");

    en = 1'b1;
    run(5, 0, 1, B, 0, 1, "R3 above base without tick");
    cyc(1, 0, B, 0, 1, "R3 tick below base");

    // two-level, 1.5x, short duration, policy off
    cyc(1, 1, X1, 1, 0, "R4 R9 start at 1.5x");
    run(24, 1, 0, X1, 1, 0, "R5 short step holds while below base");
    cyc(1, 1, B, 0, 0, "R5 R9 short step ends on 25th tick");
    run(3, 1, 1, B, 0, 0, "R7 above base keeps rearm low");
    cyc(0, 0, B, 0, 0, "R7 no tick no rearm");
    cyc(1, 0, B, 0, 1, "R7 rearm on below-base tick");

    // two-level, 2x, long duration
    hi = 1'b1; dsel = 1'b1;
    cyc(1, 1, X2, 1, 0, "R4 start at 2x");
    run(49, 1, 1, X2, 1, 0, "R5 long step holds");
    cyc(1, 1, B, 0, 0, "R5 long step ends on 50th tick");
    cyc(1, 0, B, 0, 1, "R7 rearm after long step");

    // three-level, short duration, hi_sel low
    hi = 1'b0; dsel = 1'b0; three = 1'b1;
    cyc(1, 1, X2, 1, 0, "R6 three-level starts at 2x");
    run(24, 1, 1, X2, 1, 0, "R6 first step");
    cyc(1, 1, X1, 1, 0, "R6 intermediate level");
    run(24, 1, 1, X1, 1, 0, "R6 second step");
    cyc(1, 1, B, 0, 0, "R6 back to base");
    cyc(1, 0, B, 0, 1, "R7 rearm after three-level");

    // captured settings
    three = 1'b0;
    cyc(1, 1, X1, 1, 0, "R10 start two-level short");
    dsel = 1'b1; three = 1'b1; hi = 1'b1;
    run(24, 1, 1, X1, 1, 0, "R10 mid-event changes ignored");
    cyc(1, 1, B, 0, 0, "R10 original duration kept");
    cyc(1, 0, B, 0, 1, "R10 rearm");
    dsel = 1'b0; three = 1'b0; hi = 1'b0;

    // interval policy
    tmax = 1'b1;
    cyc(1, 1, X1, 1, 0, "R8 start");
    run(24, 1, 1, X1, 1, 0, "R8 step");
    cyc(1, 1, B, 0, 0, "R8 step ends");
    run(224, 1, 1, B, 0, 0, "R8 waiting for interval");
    cyc(1, 1, B, 0, 1, "R8 rearm at 250th tick with current high");
    cyc(1, 1, X1, 1, 0, "R8 new event right after rearm");
    run(3, 1, 1, X1, 1, 0, "R8 step running");

    // disable mid-event
    en = 1'b0;
    cyc(0, 1, B, 0, 1, "R2 disable forces base");
    run(3, 1, 1, B, 0, 1, "R2 tick ignored while disabled");
    en = 1'b1; tmax = 1'b0;
    cyc(0, 0, B, 0, 1, "R2 re-enabled idle");
    cyc(1, 1, X1, 1, 0, "R3 event after re-enable");

    tick = 1'b0; over = 1'b0;
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule